// File: doc/BRIEF.md
# Programmable Serial Flash Sequence Engine

This block runs a small stored program against a serial flash device over 1, 2, 4 or 8 data lines. A table holds a number of sequences. Each sequence is four 32-bit words, and each word carries two 16-bit instructions. An instruction names a phase, the number of lines that phase uses, and an operand. The phases are command byte, address, dummy cycles, write data and read data.

A trigger supplies a sequence number, a start address and a byte count. The engine then steps through the instructions and drives the pad-level pins: chip select, serial clock, and an output value and output enable for each line. Write bytes are pulled from a transmit FIFO port. Read bytes are pushed to a receive FIFO port.

Each transfer is assembled at run time from the table contents. Software can therefore build any command format by rewriting a sequence and triggering it.

Top module: `flash_seq_engine`

## Requirements
- R1: The table is written one 32-bit word at a time, and sequence s occupies word addresses s*4 to s*4+3. Instruction i of a sequence sits in word i/2: the low half when i is even, the high half when i is odd. An instruction carries the phase code in bits [15:10], the line code in bits [9:8] and the operand in bits [7:0]. The phase codes are: end 0x00, command 0x01, address 0x02, write 0x08, read 0x09 and dummy 0x0C.
- R2: `idle` reads 1 whenever no sequence runs. A trigger is accepted only while `idle` is 1. After an accepted trigger, `cs_n` is low from the next cycle until the sequence finishes, and `idle` returns to 1 when it does.
- R3: The sequence ends at the first end instruction, at any unknown phase code, or after the eighth instruction. `cs_n` goes high in the cycle after the ending instruction is decoded.
- R4: Line code c selects 2^c lines, which are lines 0 to 2^c-1. On driven phases `io_oe` is high on exactly those lines. Bits leave most significant first, and within one beat the earlier bit sits on the higher line.
- R5: A command instruction shifts out its 8-bit operand.
- R6: An address instruction shifts out the low N bits of the trigger address, MSB first, where N is the operand limited to 32. An operand of 0 sends nothing. N is a multiple of the line count.
- R7: A dummy instruction runs min(operand, 64) serial clock cycles with every output enable low. An operand of 0 runs none.
- R8: A write instruction sends as many bytes as the trigger count. Each byte is taken from `tx_data` in a cycle where `tx_ready` and `tx_valid` are both high. The engine waits while `tx_valid` is low.
- R9: A read instruction gathers as many bytes as the trigger count from `io_in`, MSB first. It presents each byte on `rx_data` with a one-cycle `rx_valid` pulse.
- R10: When the data count of a write or read runs out, the sequence ends. A count of zero ends it as soon as that instruction is decoded. Instructions after a data instruction are never run.
- R11: A trigger while busy is ignored and leaves the running transfer unchanged. It sets `err`, which stays 1 until reset.
- R12: Each beat takes two clocks: `sck` is low for one, then high for one. `io_in` is sampled at the clock edge that ends the high cycle. `sck` stays low outside beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tbl_we | input | 1 | Table word write strobe |
| tbl_waddr | input | 7 | Table word address |
| tbl_wdata | input | 32 | Table word data |
| trig | input | 1 | Start request |
| trig_seq | input | 5 | Sequence number to run |
| trig_addr | input | 32 | Flash address for address phases |
| trig_len | input | 16 | Byte count for data phases |
| idle | output | 1 | No sequence running |
| err | output | 1 | Sticky busy-trigger flag |
| tx_data | input | 8 | Transmit FIFO byte |
| tx_valid | input | 1 | Transmit byte available |
| tx_ready | output | 1 | Transmit byte taken this cycle when valid |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte strobe |
| cs_n | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock |
| io_out | output | 8 | Line output values |
| io_oe | output | 8 | Line output enables |
| io_in | input | 8 | Line input values |

## Verification
The bench builds the engine with its default parameters: 32 sequences, a 16-bit byte count and a 64-cycle dummy limit. With these values, sequence 31 at the top of the table can be reached. Dummy operands above 64 exercise the limit, and address operands above 32 exercise the address clamp. Random programs mix all four line counts with optional address, dummy and data phases. The transmit FIFO stalls at random, so every beat and byte is checked under back-pressure.

// File: rtl/flash_seq_engine.sv
module flash_seq_engine #(
  parameter int NSEQ      = 32,
  parameter int LW        = 16,
  parameter int MAX_DUMMY = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tbl_we,
  input  logic [$clog2(NSEQ)+1:0]       tbl_waddr,
  input  logic [31:0]                   tbl_wdata,
  input  logic                          trig,
  input  logic [$clog2(NSEQ)-1:0]       trig_seq,
  input  logic [31:0]                   trig_addr,
  input  logic [LW-1:0]                 trig_len,
  output logic                          idle,
  output logic                          err,
  input  logic [7:0]                    tx_data,
  input  logic                          tx_valid,
  output logic                          tx_ready,
  output logic [7:0]                    rx_data,
  output logic                          rx_valid,
  output logic                          cs_n,
  output logic                          sck,
  output logic [7:0]                    io_out,
  output logic [7:0]                    io_oe,
  input  logic [7:0]                    io_in
);
  localparam int SW  = $clog2(NSEQ);
  localparam int TAW = SW + 2;

  localparam logic [5:0] OP_END = 6'h00, OP_CMD = 6'h01, OP_ADR = 6'h02,
                         OP_WR  = 6'h08, OP_RD  = 6'h09, OP_DUM = 6'h0C;

  typedef enum logic [2:0] {S_IDLE, S_DEC, S_TXLD, S_SHIFT, S_END} state_t;
  typedef enum logic [2:0] {K_CMD, K_ADR, K_DUM, K_WR, K_RD} kind_t;

  logic [31:0]   tbl [NSEQ*4];
  state_t        state;
  kind_t         kind;
  logic [SW-1:0] seq;
  logic [2:0]    ip;
  logic [31:0]   addr, sh;
  logic [LW-1:0] bytes;
  logic [1:0]    w;
  logic [5:0]    bits;
  logic [7:0]    dcnt, rx_sh;
  logic          ph;

  always_ff @(posedge clk)
    if (tbl_we) tbl[tbl_waddr] <= tbl_wdata;

  logic [31:0] word;
  logic [15:0] ins;
  logic [5:0]  ins_op;
  logic [7:0]  ins_opr;
  logic [5:0]  ad_bits;
  logic [7:0]  dum_cyc;
  assign word    = tbl[TAW'({seq, ip[2:1]})];
  assign ins     = ip[0] ? word[31:16] : word[15:0];
  assign ins_op  = ins[15:10];
  assign ins_opr = ins[7:0];
  assign ad_bits = (ins_opr > 8'd32) ? 6'd32 : ins_opr[5:0];
  assign dum_cyc = (ins_opr > 8'(MAX_DUMMY)) ? 8'(MAX_DUMMY) : ins_opr;

  logic [3:0] lanes;
  logic [7:0] lane_mask, rx_next;
  logic       drive, last_unit;
  assign lanes     = 4'd1 << w;
  assign lane_mask = 8'((9'd1 << lanes) - 9'd1);
  assign rx_next   = 8'(rx_sh << lanes) | (io_in & lane_mask);
  assign last_unit = bits <= {2'b00, lanes};
  assign drive     = (state == S_SHIFT) && (kind == K_CMD || kind == K_ADR || kind == K_WR);

  assign idle     = state == S_IDLE;
  assign tx_ready = state == S_TXLD;
  assign sck      = (state == S_SHIFT) && ph;
  assign io_oe    = drive ? lane_mask : 8'd0;
  assign io_out   = drive ? (sh[31:24] >> (4'd8 - lanes)) : 8'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      kind     <= K_CMD;
      seq      <= '0;
      ip       <= '0;
      addr     <= '0;
      sh       <= '0;
      bytes    <= '0;
      w        <= '0;
      bits     <= '0;
      dcnt     <= '0;
      rx_sh    <= '0;
      ph       <= 1'b0;
      err      <= 1'b0;
      cs_n     <= 1'b1;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (trig && state != S_IDLE) err <= 1'b1;
      case (state)
        S_IDLE: if (trig) begin
          seq   <= trig_seq;
          addr  <= trig_addr;
          bytes <= trig_len;
          ip    <= '0;
          cs_n  <= 1'b0;
          state <= S_DEC;
        end
        S_DEC: begin
          w  <= ins[9:8];
          ph <= 1'b0;
          case (ins_op)
            OP_CMD: begin
              kind  <= K_CMD;
              sh    <= {ins_opr, 24'd0};
              bits  <= 6'd8;
              state <= S_SHIFT;
            end
            OP_ADR:
              if (ad_bits == 6'd0) begin
                if (ip == 3'd7) begin cs_n <= 1'b1; state <= S_END; end
                else ip <= ip + 3'd1;
              end else begin
                kind  <= K_ADR;
                sh    <= addr << (6'd32 - ad_bits);
                bits  <= ad_bits;
                state <= S_SHIFT;
              end
            OP_DUM:
              if (dum_cyc == 8'd0) begin
                if (ip == 3'd7) begin cs_n <= 1'b1; state <= S_END; end
                else ip <= ip + 3'd1;
              end else begin
                kind  <= K_DUM;
                sh    <= '0;
                dcnt  <= dum_cyc;
                state <= S_SHIFT;
              end
            OP_WR:
              if (bytes == '0) begin cs_n <= 1'b1; state <= S_END; end
              else begin kind <= K_WR; state <= S_TXLD; end
            OP_RD:
              if (bytes == '0) begin cs_n <= 1'b1; state <= S_END; end
              else begin
                kind  <= K_RD;
                sh    <= '0;
                bits  <= 6'd8;
                rx_sh <= '0;
                state <= S_SHIFT;
              end
            default: begin cs_n <= 1'b1; state <= S_END; end
          endcase
        end
        S_TXLD: if (tx_valid) begin
          sh    <= {tx_data, 24'd0};
          bits  <= 6'd8;
          ph    <= 1'b0;
          state <= S_SHIFT;
        end
        S_SHIFT: begin
          ph <= ~ph;
          if (ph) begin
            sh    <= sh << lanes;
            rx_sh <= rx_next;
            if (kind == K_DUM) begin
              if (dcnt == 8'd1) begin
                if (ip == 3'd7) begin cs_n <= 1'b1; state <= S_END; end
                else begin ip <= ip + 3'd1; state <= S_DEC; end
              end else dcnt <= dcnt - 8'd1;
            end else if (last_unit) begin
              case (kind)
                K_WR: begin
                  bytes <= bytes - 1'b1;
                  if (bytes == LW'(1)) begin cs_n <= 1'b1; state <= S_END; end
                  else state <= S_TXLD;
                end
                K_RD: begin
                  rx_data  <= rx_next;
                  rx_valid <= 1'b1;
                  rx_sh    <= '0;
                  bytes    <= bytes - 1'b1;
                  bits     <= 6'd8;
                  if (bytes == LW'(1)) begin cs_n <= 1'b1; state <= S_END; end
                end
                default:
                  if (ip == 3'd7) begin cs_n <= 1'b1; state <= S_END; end
                  else begin ip <= ip + 3'd1; state <= S_DEC; end
              endcase
            end else bits <= bits - {2'b00, lanes};
          end
        end
        S_END:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r2_idle_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> cs_n);
  a_r2_accept_selects: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && trig) |=> (!cs_n && !idle));
  a_r3_end_deselects: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DEC && ins_op == OP_END) |=> (cs_n && !idle));
  a_r4_oe_low_group: assert property (@(posedge clk) disable iff (!rst_n)
    ((io_oe & (io_oe + 8'd1)) == 8'd0) && ((io_out & ~io_oe) == 8'd0));
  a_r8_pop_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !cs_n);
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  a_r11_busy_trig_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !idle) |=> err);
  a_r12_sck_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> (!cs_n && !$past(sck)));
endmodule

// File: tb/sim_flash_seq_engine.sv
module sim_flash_seq_engine;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, tbl_we, trig, tx_valid;
  logic [6:0]  tbl_waddr;
  logic [31:0] tbl_wdata, trig_addr;
  logic [4:0]  trig_seq;
  logic [15:0] trig_len;
  logic [7:0]  tx_data, io_in;
  logic        idle, err, tx_ready, rx_valid, cs_n, sck;
  logic [7:0]  rx_data, io_out, io_oe;

  flash_seq_engine u0 (.clk, .rst_n, .tbl_we, .tbl_waddr, .tbl_wdata, .trig, .trig_seq,
    .trig_addr, .trig_len, .idle, .err, .tx_data, .tx_valid, .tx_ready, .rx_data,
    .rx_valid, .cs_n, .sck, .io_out, .io_oe, .io_in);

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0]  rdin [1024];
  logic [7:0]  txb  [64];
  logic [15:0] eb[$], gb[$];
  logic [7:0]  erx[$], grx[$];
  int          etx;
  logic [15:0] prog [8];

  task automatic chk(input bit ok, input string r, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [15:0] mk(input logic [5:0] op, input logic [1:0] pad, input logic [7:0] opr);
    return {op, pad, opr};
  endfunction

  task automatic model(input logic [31:0] a, input int len);
    eb.delete(); erx.delete(); etx = 0;
    for (int i = 0; i < 8; i++) begin
      int op, w, m, opr, n;
      op = prog[i][15:10]; w = 1 << prog[i][9:8]; m = (1 << w) - 1; opr = prog[i][7:0];
      if (op == 1) begin
        for (int b = 0; b < 8; b += w) eb.push_back({8'(m), 8'((opr >> (8 - w - b)) & m)});
      end else if (op == 2) begin
        n = (opr > 32) ? 32 : opr;
        for (int b = 0; b < n; b += w) eb.push_back({8'(m), 8'((a >> (n - w - b)) & m)});
      end else if (op == 12) begin
        n = (opr > 64) ? 64 : opr;
        for (int c = 0; c < n; c++) eb.push_back(16'd0);
      end else if (op == 8) begin
        for (int j = 0; j < len; j++) begin
          etx++;
          for (int b = 0; b < 8; b += w) eb.push_back({8'(m), 8'((txb[j] >> (8 - w - b)) & m)});
        end
        break;
      end else if (op == 9) begin
        for (int j = 0; j < len; j++) begin
          int r = 0;
          for (int b = 0; b < 8; b += w) begin
            r = (r << w) | (rdin[eb.size()] & m);
            eb.push_back(16'd0);
          end
          erx.push_back(8'(r));
        end
        break;
      end else break;
    end
  endtask

  task automatic load(input logic [4:0] s);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      tbl_we = 1'b1; tbl_waddr = {s, 2'(k)}; tbl_wdata = {prog[2*k+1], prog[2*k]};
    end
    @(negedge clk); tbl_we = 1'b0;
  endtask

  task automatic run(input logic [4:0] s, input logic [31:0] a, input int len, input string tag, input int busy_at);
    int tx_idx, n, bad;
    bit pend;
    for (int i = 0; i < 1024; i++) rdin[i] = 8'($urandom);
    for (int i = 0; i < 64; i++) txb[i] = 8'($urandom);
    model(a, len);
    gb.delete(); grx.delete();
    tx_idx = 0; pend = 0; tx_data = txb[0]; n = 0;
    @(negedge clk);
    trig = 1'b1; trig_seq = s; trig_addr = a; trig_len = 16'(len);
    @(negedge clk);
    trig = 1'b0;
    forever begin
      if (pend) begin tx_idx++; tx_data = txb[tx_idx % 64]; pend = 0; end
      tx_valid = ($urandom % 4) != 0;
      pend = tx_ready && tx_valid;
      if (sck) begin gb.push_back({io_oe, io_out}); io_in = rdin[(gb.size() - 1) % 1024]; end
      if (rx_valid) grx.push_back(rx_data);
      if (n == busy_at) begin trig = 1'b1; trig_seq = s + 5'd1; trig_addr = ~a; trig_len = 16'd3; end
      else trig = 1'b0;
      if (idle || n > 20000) break;
      n++;
      @(negedge clk);
    end
    trig = 1'b0; tx_valid = 1'b0;
    chk(gb.size() == eb.size(), tag, "beat count", gb.size(), eb.size());
    bad = -1;
    foreach (eb[i]) if (i < gb.size() && gb[i] !== eb[i] && bad < 0) bad = i;
    chk(bad < 0, tag, "beat oe/out", bad < 0 ? 0 : gb[bad], bad < 0 ? 0 : eb[bad]);
    chk(grx == erx, tag, "read bytes", grx.size() ? grx[grx.size()-1] : 0, erx.size() ? erx[erx.size()-1] : 0);
    chk(grx.size() == erx.size(), tag, "read byte count", grx.size(), erx.size());
    chk(tx_idx == etx, tag, "tx pops", tx_idx, etx);
    chk(idle && cs_n && !sck, "R2", "idle deselected after run", {idle, cs_n, sck}, 3'b110);
  endtask

  task automatic clr();
    for (int i = 0; i < 8; i++) prog[i] = 16'd0;
  endtask

  initial begin
    rst_n = 0; tbl_we = 0; trig = 0; tx_valid = 0; io_in = 0;
    tbl_waddr = 0; tbl_wdata = 0; trig_seq = 0; trig_addr = 0; trig_len = 0; tx_data = 0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(idle && cs_n && !sck && !err && io_oe == 0 && !rx_valid, "R2", "reset state",
        {idle, cs_n, sck, err}, 4'b1100);

    clr(); prog[0] = mk(6'h01, 2'd0, 8'h9F); prog[1] = mk(6'h09, 2'd0, 8'h00);
    load(5'd5); run(5'd5, 32'h0, 3, "R5 R9 single-line id read", -1);

    clr(); prog[0] = mk(6'h01, 2'd0, 8'hEB); prog[1] = mk(6'h02, 2'd2, 8'd24);
    prog[2] = mk(6'h0C, 2'd2, 8'd6); prog[3] = mk(6'h09, 2'd2, 8'd0);
    load(5'd31); run(5'd31, 32'h00A1B2C3, 5, "R1 R4 R6 quad read last sequence", -1);

    clr(); prog[0] = mk(6'h01, 2'd3, 8'h12); prog[1] = mk(6'h02, 2'd3, 8'd32);
    prog[2] = mk(6'h08, 2'd3, 8'd0);
    load(5'd2); run(5'd2, 32'hDEADBEEF, 4, "R8 octal write", -1);

    clr(); prog[0] = mk(6'h01, 2'd1, 8'h3B); prog[1] = mk(6'h02, 2'd1, 8'd40);
    prog[2] = mk(6'h0C, 2'd1, 8'd200); prog[3] = mk(6'h09, 2'd1, 8'd0);
    load(5'd7); run(5'd7, 32'h87654321, 2, "R6 R7 dual clamp address and dummy", -1);

    clr(); prog[0] = mk(6'h01, 2'd0, 8'h03); prog[1] = mk(6'h09, 2'd0, 8'd0);
    prog[2] = mk(6'h01, 2'd0, 8'hFF);
    load(5'd8); run(5'd8, 32'h0, 0, "R10 zero count ends", -1);

    clr(); prog[0] = mk(6'h08, 2'd0, 8'd0); prog[1] = mk(6'h01, 2'd0, 8'hAA);
    load(5'd9); run(5'd9, 32'h0, 2, "R10 after data stops", -1);

    clr(); for (int i = 0; i < 8; i++) prog[i] = mk(6'h01, 2'(i % 4), 8'(8'h11 * i));
    load(5'd10); run(5'd10, 32'h0, 0, "R3 eight instructions", -1);

    clr(); prog[0] = mk(6'h01, 2'd0, 8'h66); prog[1] = mk(6'h15, 2'd0, 8'd0);
    prog[2] = mk(6'h01, 2'd0, 8'h99);
    load(5'd11); run(5'd11, 32'h0, 0, "R3 unknown code ends", -1);

    clr(); prog[0] = mk(6'h01, 2'd0, 8'hC5); prog[1] = mk(6'h0C, 2'd0, 8'd0);
    prog[2] = mk(6'h02, 2'd0, 8'd0); prog[3] = mk(6'h01, 2'd2, 8'h5C);
    load(5'd12); run(5'd12, 32'h0, 0, "R6 R7 zero operands skip", -1);

    chk(!err, "R11", "err clear before busy trigger", err, 0);
    clr(); prog[0] = mk(6'h01, 2'd0, 8'h0B); prog[1] = mk(6'h02, 2'd0, 8'd24);
    prog[2] = mk(6'h09, 2'd0, 8'd0);
    load(5'd13); run(5'd13, 32'h123456, 2, "R11 busy trigger ignored", 10);
    chk(err, "R11", "err set by busy trigger", err, 1);
    repeat (3) @(negedge clk);
    chk(err && idle && cs_n, "R11", "err sticky", err, 1);

    for (int t = 0; t < 24; t++) begin
      int k = 0, len;
      logic [4:0] s;
      clr();
      prog[k++] = mk(6'h01, 2'($urandom), 8'($urandom));
      if ($urandom % 2) prog[k++] = mk(6'h02, 2'($urandom), 8'(8 * (1 + $urandom % 4)));
      if ($urandom % 2) prog[k++] = mk(6'h0C, 2'($urandom), 8'($urandom % 72));
      if ($urandom % 4 != 0) prog[k++] = mk(($urandom % 2) ? 6'h08 : 6'h09, 2'($urandom), 8'($urandom));
      len = $urandom % 7;
      s = 5'($urandom);
      load(s);
      run(s, $urandom, len, "R4 R12 random program", -1);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule